// File: doc/BRIEF.md
# Lockable Receive Queue with Command Byte

This block is the holding queue between a serial receiver and a host. Each entry is one received character together with its status bits, 11 bits wide, and up to four entries are held. The receiver hands over a finished entry with a one-cycle push strobe. The host reads the entry at the head of the queue and removes it with a read strobe. The number of entries that may be held, called the effective depth, can be set from 1 to 4. A threshold flag tells the host when the fill level has reached a programmed value.

A single command byte controls the queue. Several actions can be combined in one write: turn reception on or off, reset the receive machine, empty the queue, lock it, unlock it, and clear the overrun status. While the queue is locked it refuses new entries. Locking and unlocking never move the read or write positions, so the stored entries survive. A reset of the receive machine always leaves the queue unlocked, even when a lock is requested in the same byte. A read strobe on an empty queue has no effect, so the read and write positions cannot drift apart.

Top module: `rxq_lockfifo`

## Requirements
- R1: After reset, `fill_level` is 0 and `rd_avail`, `q_locked`, `rx_on`, `overrun` and `thresh_hit` are all 0.
- R2: Entries accepted by the queue leave it in the order they arrived. `rd_word` shows the oldest entry whenever `rd_avail` is 1. Each accepted push raises `fill_level` by one and each effective read lowers it by one, both at the next clock edge.
- R3: The effective depth is `cfg_depth`, with 0 read as 1 and values above 4 read as 4. A push while `fill_level` is at or above the effective depth is refused and sets `overrun`. The stored entries and `fill_level` are kept.
- R4: `thresh_hit` is 1 exactly when `fill_level` is greater than or equal to `cfg_thresh`, with a threshold of 0 read as 1.
- R5: A read strobe while the queue is empty leaves `fill_level` at 0. Later pushes and reads return the correct data.
- R6: Command bit 0 turns reception on and bit 1 turns it off; when both are set, off wins. While reception is off, pushes are ignored and do not set `overrun`.
- R7: Command bit 4 locks the queue. While it is locked, pushes are discarded and set `overrun`, and reads still remove entries.
- R8: Command bit 5 unlocks the queue. Neither locking nor unlocking changes `fill_level` or the stored entries.
- R9: Command bit 2 resets the receive machine and leaves the queue unlocked, even when bit 4 is set in the same byte.
- R10: Command bit 3 empties the queue: `fill_level` becomes 0 at the next edge. A push in the same cycle is dropped without setting `overrun`, and the next accepted entry is the next one read.
- R11: Command bit 6 clears `overrun`. If a push is refused in the same cycle, `overrun` ends up set.
- R12: A command takes effect at the clock edge that captures it. A push in the same cycle is judged against the state before that edge. Command bit 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_push | input | 1 | Receiver offers an entry this cycle |
| rx_word | input | DATA_W (11) | Entry offered by the receiver |
| rd_req | input | 1 | Host removes the head entry |
| rd_word | output | DATA_W (11) | Head entry |
| rd_avail | output | 1 | Queue holds at least one entry |
| cmd_wr | input | 1 | Command byte is valid this cycle |
| cmd_byte | input | 8 | Command bits, see R6 to R12 |
| cfg_depth | input | CNT_W (3) | Effective depth setting |
| cfg_thresh | input | CNT_W (3) | Fill threshold setting |
| rx_on | output | 1 | Reception is on |
| q_locked | output | 1 | Queue is locked |
| fill_level | output | CNT_W (3) | Number of entries held |
| thresh_hit | output | 1 | Fill level has reached the threshold |
| overrun | output | 1 | An entry was lost to a full or locked queue |

## Verification
`fill_level`, `rx_on`, `q_locked` and `overrun` are registers, so each one reflects a push, read or command one clock edge after it is presented. `rd_word`, `rd_avail` and `thresh_hit` follow combinationally from those registers, with no extra delay. Stimulus is applied on the falling edge. The level and flag checks are made on the next falling edge, which is one edge later, and that single-edge latency is what the checks expect. The read monitor compares `rd_word` with the scoreboard's oldest entry 2 ns after the falling edge on which the read strobe is raised. At that moment the head has not yet been removed.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   // bit positions inside the command byte
   localparam int unsigned CB_RX_ON     = 0;
   localparam int unsigned CB_RX_OFF    = 1;
   localparam int unsigned CB_MACH_RST  = 2;
   localparam int unsigned CB_Q_EMPTY   = 3;
   localparam int unsigned CB_Q_LOCK    = 4;
   localparam int unsigned CB_Q_UNLOCK  = 5;
   localparam int unsigned CB_STAT_CLR  = 6;
   localparam int unsigned CB_USED_BITS = 7;

   typedef struct packed {
      logic rx_on;
      logic rx_off;
      logic mach_rst;
      logic q_empty;
      logic q_lock;
      logic q_unlock;
      logic stat_clr;
   } rxq_cmd_t;

   function automatic rxq_cmd_t rxq_decode(input logic [CB_USED_BITS-1:0] b);
      rxq_cmd_t c;
      c.rx_on    = b[CB_RX_ON];
      c.rx_off   = b[CB_RX_OFF];
      c.mach_rst = b[CB_MACH_RST];
      c.q_empty  = b[CB_Q_EMPTY];
      c.q_lock   = b[CB_Q_LOCK];
      c.q_unlock = b[CB_Q_UNLOCK];
      c.stat_clr = b[CB_STAT_CLR];
      return c;
   endfunction

endpackage

// File: rtl/rxq_cmd_ctrl.sv
module rxq_cmd_ctrl
   import rxq_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_wr,
   input  logic [CB_USED_BITS-1:0] cmd_bits,
   output rxq_cmd_t                cmd,
   output logic                    rx_on,
   output logic                    q_locked
);

   rxq_cmd_t raw;
   logic     rx_on_d;
   logic     lock_d;

   always_comb begin
      raw = rxq_decode(cmd_bits);
      cmd = cmd_wr ? raw : '0;
   end

   // turning reception off outranks turning it on
   always_comb begin
      rx_on_d = rx_on;
      if (cmd.rx_off)
         rx_on_d = 1'b0;
      else if (cmd.rx_on)
         rx_on_d = 1'b1;
   end

   // a machine reset or an explicit unlock outranks a lock request
   always_comb begin
      lock_d = q_locked;
      if (cmd.mach_rst || cmd.q_unlock)
         lock_d = 1'b0;
      else if (cmd.q_lock)
         lock_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_on    <= 1'b0;
         q_locked <= 1'b0;
      end else begin
         rx_on    <= rx_on_d;
         q_locked <= lock_d;
      end
   end

endmodule

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl #(
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop_req,
   input  logic             rx_on,
   input  logic             q_locked,
   input  logic             q_empty,
   input  logic             stat_clr,
   input  logic [CNT_W-1:0] eff_depth,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_idx,
   output logic [PTR_W-1:0] rd_idx,
   output logic [CNT_W-1:0] count,
   output logic             overrun
);

   logic pop_ok;
   logic room;
   logic take;
   logic lose;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   always_comb begin
      pop_ok = pop_req && (count != '0) && !q_empty;
      room   = count < eff_depth;
      take   = push && rx_on && !q_locked && room && !q_empty;
      lose   = push && rx_on && (q_locked || !room) && !q_empty;
      wr_en  = take;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_idx <= '0;
         rd_idx <= '0;
         count  <= '0;
      end else if (q_empty) begin
         wr_idx <= '0;
         rd_idx <= '0;
         count  <= '0;
      end else begin
         if (take)
            wr_idx <= bump(wr_idx);
         if (pop_ok)
            rd_idx <= bump(rd_idx);
         case ({take, pop_ok})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         overrun <= 1'b0;
      else if (lose)
         overrun <= 1'b1;
      else if (stat_clr)
         overrun <= 1'b0;
   end

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned DEPTH       = 4,
   parameter int unsigned DATA_W      = 11,
   parameter bit          STORE_RESET = 1'b0,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_word,
   input  logic [PTR_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_word
);

   logic [DATA_W-1:0] slot [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (STORE_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot[i] <= '0;
            else if (wr_en && wr_idx == PTR_W'(i))
               slot[i] <= wr_word;
         end
      end else begin : g_norst
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (wr_en && wr_idx == PTR_W'(i))
               slot[i] <= wr_word;
         end
      end
   end

   assign rd_word = slot[rd_idx];

endmodule

// File: rtl/rxq_lockfifo.sv
module rxq_lockfifo
   import rxq_pkg::*;
#(
   parameter int unsigned DATA_W      = 11,
   parameter int unsigned DEPTH       = 4,
   parameter bit          STORE_RESET = 1'b0,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_word,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_word,
   output logic              rd_avail,
   input  logic              cmd_wr,
   input  logic [7:0]        cmd_byte,
   input  logic [CNT_W-1:0]  cfg_depth,
   input  logic [CNT_W-1:0]  cfg_thresh,
   output logic              rx_on,
   output logic              q_locked,
   output logic [CNT_W-1:0]  fill_level,
   output logic              thresh_hit,
   output logic              overrun
);

   if (DEPTH < 1 || DEPTH > 16) begin : g_bad_depth
      $error("rxq_lockfifo: DEPTH must be within 1..16");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rxq_lockfifo: DATA_W must be positive");
   end

   rxq_cmd_t         cmd;
   logic             wr_en;
   logic [PTR_W-1:0] wr_idx;
   logic [PTR_W-1:0] rd_idx;
   logic [CNT_W-1:0] eff_depth;
   logic [CNT_W-1:0] eff_thresh;
   logic             cmd_unused;

   assign cmd_unused = cmd_byte[7];

   always_comb begin
      if (cfg_depth == '0)
         eff_depth = CNT_W'(1);
      else if (cfg_depth > CNT_W'(DEPTH))
         eff_depth = CNT_W'(DEPTH);
      else
         eff_depth = cfg_depth;
      eff_thresh = (cfg_thresh == '0) ? CNT_W'(1) : cfg_thresh;
   end

   rxq_cmd_ctrl u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (cmd_wr),
      .cmd_bits (cmd_byte[CB_USED_BITS-1:0]),
      .cmd      (cmd),
      .rx_on    (rx_on),
      .q_locked (q_locked)
   );

   rxq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rx_push),
      .pop_req   (rd_req),
      .rx_on     (rx_on),
      .q_locked  (q_locked),
      .q_empty   (cmd.q_empty),
      .stat_clr  (cmd.stat_clr),
      .eff_depth (eff_depth),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .rd_idx    (rd_idx),
      .count     (fill_level),
      .overrun   (overrun)
   );

   rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .STORE_RESET(STORE_RESET)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_word (rx_word),
      .rd_idx  (rd_idx),
      .rd_word (rd_word)
   );

   assign rd_avail   = fill_level != '0;
   assign thresh_hit = fill_level >= eff_thresh;

endmodule

// File: rtl/rxq_lockfifo_chk.sv
module rxq_lockfifo_chk #(
   parameter int unsigned CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_push,
   input logic             rd_req,
   input logic             cmd_wr,
   input logic             c_off,
   input logic             c_mrst,
   input logic             c_empty,
   input logic             c_lock,
   input logic             c_unlock,
   input logic             c_clr,
   input logic             rx_on,
   input logic             q_locked,
   input logic [CNT_W-1:0] fill_level,
   input logic             thresh_hit,
   input logic             overrun
);

   p_level_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_wr && c_empty) |=>
         (int'(fill_level) - int'($past(fill_level)) <= 1) &&
         (int'($past(fill_level)) - int'(fill_level) <= 1));

   p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_level == '0 && !rx_push) |=> fill_level == '0);

   p_no_thresh_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_level == '0 |-> !thresh_hit);

   p_off_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && c_off) |=> !rx_on);

   p_off_no_growth_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_on |=> fill_level <= $past(fill_level));

   p_locked_no_growth_r7: assert property (@(posedge clk) disable iff (!rst_n)
      q_locked |=> fill_level <= $past(fill_level));

   p_lock_keeps_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && (c_lock || c_unlock) && !c_empty && !rx_push && !rd_req)
         |=> $stable(fill_level));

   p_unlock_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && c_mrst) |=> !q_locked);

   p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && c_empty) |=> fill_level == '0);

   p_stat_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && c_clr && !rx_push) |=> !overrun);

endmodule

bind rxq_lockfifo rxq_lockfifo_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_push    (rx_push),
   .rd_req     (rd_req),
   .cmd_wr     (cmd_wr),
   .c_off      (cmd_byte[1]),
   .c_mrst     (cmd_byte[2]),
   .c_empty    (cmd_byte[3]),
   .c_lock     (cmd_byte[4]),
   .c_unlock   (cmd_byte[5]),
   .c_clr      (cmd_byte[6]),
   .rx_on      (rx_on),
   .q_locked   (q_locked),
   .fill_level (fill_level),
   .thresh_hit (thresh_hit),
   .overrun    (overrun)
);

// File: tb/sim_rxq_lockfifo.sv
module sim_rxq_lockfifo;

   localparam int DATA_W = 11;
   localparam int CNT_W  = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rx_push = 1'b0;
   logic [DATA_W-1:0] rx_word = '0;
   logic              rd_req = 1'b0;
   logic [DATA_W-1:0] rd_word;
   logic              rd_avail;
   logic              cmd_wr = 1'b0;
   logic [7:0]        cmd_byte = '0;
   logic [CNT_W-1:0]  cfg_depth = 3'd4;
   logic [CNT_W-1:0]  cfg_thresh = 3'd3;
   logic              rx_on;
   logic              q_locked;
   logic [CNT_W-1:0]  fill_level;
   logic              thresh_hit;
   logic              overrun;

   int n_vec = 0;
   int n_bad = 0;
   logic [DATA_W-1:0] sb[$];

   always #4 clk = ~clk;

   rxq_lockfifo u0 (
      .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_word(rx_word),
      .rd_req(rd_req), .rd_word(rd_word), .rd_avail(rd_avail),
      .cmd_wr(cmd_wr), .cmd_byte(cmd_byte), .cfg_depth(cfg_depth),
      .cfg_thresh(cfg_thresh), .rx_on(rx_on), .q_locked(q_locked),
      .fill_level(fill_level), .thresh_hit(thresh_hit), .overrun(overrun)
   );

   task automatic check(input string tag, input int got, input int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // one cycle of stimulus, entered and left on a falling edge
   task automatic drive(input logic pv, input logic [DATA_W-1:0] pd, input logic pr,
                        input logic cw, input logic [7:0] cb, input logic acc);
      rx_push  = pv;
      rx_word  = pd;
      rd_req   = pr;
      cmd_wr   = cw;
      cmd_byte = cb;
      if (pv && acc) sb.push_back(pd);
      if (cw && cb[3]) sb.delete();
      @(negedge clk);
      rx_push = 1'b0; rd_req = 1'b0; cmd_wr = 1'b0; cmd_byte = '0;
   endtask

   task automatic push(input logic [DATA_W-1:0] d, input logic acc);
      drive(1'b1, d, 1'b0, 1'b0, 8'h00, acc);
   endtask
   task automatic pop();
      drive(1'b0, '0, 1'b1, 1'b0, 8'h00, 1'b0);
   endtask
   task automatic cmd(input logic [7:0] b);
      drive(1'b0, '0, 1'b0, 1'b1, b, 1'b0);
   endtask

   // monitor: compares the head against the scoreboard while a read is raised
   always @(negedge clk) begin
      #2;
      if (rd_req) begin
         if (sb.size() == 0) begin
            check("R5 read on empty shows no entry", int'(rd_avail), 0);
         end else begin
            check("R2 avail on read", int'(rd_avail), 1);
            check("R2 head order", int'(rd_word), int'(sb[0]));
            void'(sb.pop_front());
         end
      end
   end

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1 level", int'(fill_level), 0);
      check("R1 avail", int'(rd_avail), 0);
      check("R1 locked", int'(q_locked), 0);
      check("R1 rx_on", int'(rx_on), 0);
      check("R1 overrun", int'(overrun), 0);
      check("R1 thresh", int'(thresh_hit), 0);

      // R6: receiver off ignores pushes
      push(11'h111, 1'b0);
      check("R6 off push level", int'(fill_level), 0);
      check("R6 off push overrun", int'(overrun), 0);
      cmd(8'h01);
      check("R6 on", int'(rx_on), 1);

      // R2 / R4
      push(11'h7A1, 1'b1);
      push(11'h052, 1'b1);
      check("R2 level after two", int'(fill_level), 2);
      check("R4 below threshold", int'(thresh_hit), 0);
      push(11'h3C3, 1'b1);
      check("R4 at threshold", int'(thresh_hit), 1);
      pop(); pop(); pop();
      check("R2 drained", int'(fill_level), 0);

      // R5
      pop(); pop();
      check("R5 level stays zero", int'(fill_level), 0);
      push(11'h2D4, 1'b1);
      pop();
      check("R5 after resync", int'(fill_level), 0);

      // R3
      cfg_depth = 3'd2;
      push(11'h0E5, 1'b1);
      push(11'h1F6, 1'b1);
      push(11'h4A7, 1'b0);
      check("R3 full level", int'(fill_level), 2);
      check("R3 overrun", int'(overrun), 1);
      pop(); pop();

      // R11
      cmd(8'h40);
      check("R11 cleared", int'(overrun), 0);
      cfg_depth = 3'd1;
      push(11'h588, 1'b1);
      drive(1'b1, 11'h699, 1'b0, 1'b1, 8'h40, 1'b0);
      check("R11 set beats clear", int'(overrun), 1);
      cmd(8'h40);
      check("R11 cleared again", int'(overrun), 0);
      pop();

      // R7 / R8
      cfg_depth = 3'd4;
      push(11'h12A, 1'b1);
      cmd(8'h10);
      check("R7 locked", int'(q_locked), 1);
      check("R8 lock keeps level", int'(fill_level), 1);
      push(11'h23B, 1'b0);
      check("R7 locked push level", int'(fill_level), 1);
      check("R7 locked push overrun", int'(overrun), 1);
      cmd(8'h20);
      check("R8 unlocked", int'(q_locked), 0);
      check("R8 unlock keeps level", int'(fill_level), 1);
      pop();
      push(11'h34C, 1'b1);
      pop();
      cmd(8'h40);

      // R12: push in same cycle as lock is judged before the edge; bit 7 inert
      drive(1'b1, 11'h45D, 1'b0, 1'b1, 8'h90, 1'b1);
      check("R12 push with lock taken", int'(fill_level), 1);
      check("R12 lock applied", int'(q_locked), 1);
      check("R12 bit7 keeps rx_on", int'(rx_on), 1);

      // R9
      cmd(8'h14);
      check("R9 machine reset beats lock", int'(q_locked), 0);
      check("R9 level kept", int'(fill_level), 1);
      pop();
      cmd(8'h10);
      cmd(8'h04);
      check("R9 machine reset unlocks", int'(q_locked), 0);

      // R10
      push(11'h56E, 1'b1);
      push(11'h67F, 1'b1);
      drive(1'b1, 11'h780, 1'b0, 1'b1, 8'h08, 1'b0);
      check("R10 emptied", int'(fill_level), 0);
      check("R10 dropped push no overrun", int'(overrun), 0);
      push(11'h091, 1'b1);
      pop();
      check("R10 after refill", int'(fill_level), 0);

      // R6: off beats on
      cmd(8'h03);
      check("R6 off wins", int'(rx_on), 0);
      push(11'h1A2, 1'b0);
      check("R6 off level", int'(fill_level), 0);

      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule